// File: doc/BRIEF.md
# Interrupt Source Aggregator

This block merges the fault and event sources of a system-monitoring device into one shared interrupt line. The sources are fan hot-plug events, a software force request, general-purpose input pins, temperature limit events, fan tachometer over-limit events, fan fault pins and analog-input limit events. Every source passes through its own enable before it can reach the line. Register decoding sits outside the block, so the configuration bits arrive already split into individual enable and mode signals.

Some sources deliver one-cycle event pulses: hot-plug, tachometer over-limit, and the high-limit and low-limit crossings of the temperature and analog channels. An enabled pulse sets a sticky latch, and the latch holds until the host clears it through a masked clear request. The force request, the input pins and the fan fault pins are levels, and the block evaluates them again on every cycle. The line is open-drain, so the block drives only a pull-down enable. The polarity setting decides whether an active interrupt pulls the line low or releases it.

Top module: `irq_agg_top`

## Requirements
- R1: While `rstN` is low, `latchedEvt` is all zero and `intOe` is 0, which releases the line.
- R2: One cycle after the internal active condition changes, `intOe` equals that condition XOR `cfgPolHigh`. With `cfgPolHigh`=0, an active interrupt pulls the line low. With `cfgPolHigh`=1, the line is pulled low only while no source is active.
- R3: `cfgForce`=1 makes the interrupt active for as long as it is held. It latches nothing.
- R4: A `hotPlugEvt[f]` pulse always sets latch bit f. The latch layout is: bits 1:0 hot-plug fan 0/1, bits 3:2 tach fan 0/1, bits 6:4 temperature high ch 0..2, bits 9:7 temperature low ch 0..2, bits 11:10 analog high ch 0/1, bits 13:12 analog low ch 0/1. Any set latch bit keeps the interrupt active.
- R5: Input pin g is active only when `gpioIsInput[g]` and `gpioIrqEn[g]` are both 1 and `gpioPin[g]` equals `gpioAssertHigh[g]`. It is a level source and latches nothing.
- R6: `fanIrqEn[f]` enables two things for fan f. A `tachOverEvt[f]` pulse latches bit 2+f. `fanFaultN[f]`=0 acts as an active level.
- R7: A `tempHiEvt[t]` pulse latches bit 4+t only when `tempHiEn[t]`=1.
- R8: A temperature low-limit crossing latches bit 7+t only when `tempLoEn[t]`=1. With `tempLoRising[t]`=1, only `tempLoUpEvt[t]` counts. With `tempLoRising[t]`=0, only `tempLoDnEvt[t]` counts.
- R9: Analog channel a follows the same rules with `ainHiEn`, `ainLoEn` and `ainLoRising`. It latches bit 10+a for a high event and bit 12+a for the qualified low crossing.
- R10: An event pulse whose enable is 0 leaves `latchedEvt` and `intOe` unchanged.
- R11: `clrReq`=1 clears the latch bits selected by `clrMask`. A bit that is set and cleared in the same cycle ends up set. Unselected bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgForce | input | 1 | Software force of the interrupt |
| cfgPolHigh | input | 1 | 1 = active-high line, 0 = active-low line |
| hotPlugEvt | input | 2 | Hot-plug event pulse per fan |
| gpioPin | input | 4 | Input pin levels |
| gpioIsInput | input | 4 | Pin configured as input |
| gpioAssertHigh | input | 4 | Pin asserted level (1 = high) |
| gpioIrqEn | input | 4 | Pin interrupt enable |
| fanIrqEn | input | 2 | Fan interrupt enable |
| tachOverEvt | input | 2 | Tach over-limit pulse per fan |
| fanFaultN | input | 2 | Fan fault pin, low = fault |
| tempHiEn | input | 3 | Temperature high-limit enable |
| tempLoEn | input | 3 | Temperature low-crossing enable |
| tempLoRising | input | 3 | Low-crossing direction, 1 = upward |
| tempHiEvt | input | 3 | Temperature above-high pulse |
| tempLoUpEvt | input | 3 | Upward low-limit crossing pulse |
| tempLoDnEvt | input | 3 | Downward low-limit crossing pulse |
| ainHiEn | input | 2 | Analog high-limit enable |
| ainLoEn | input | 2 | Analog low-crossing enable |
| ainLoRising | input | 2 | Analog crossing direction, 1 = upward |
| ainHiEvt | input | 2 | Analog above-high pulse |
| ainLoUpEvt | input | 2 | Analog upward low crossing pulse |
| ainLoDnEvt | input | 2 | Analog downward low crossing pulse |
| clrReq | input | 1 | Latch clear strobe |
| clrMask | input | 14 | Latch bits to clear |
| latchedEvt | output | 14 | Sticky event latches |
| intOe | output | 1 | Pull-down enable of the open-drain line |

## Verification
Every combination of input-mode, enable and match-level bits is swept against both pin levels and both line polarities. This separates a pin that is truly armed from one that lacks only a single qualifier. For each temperature and analog channel, all eight enable/direction settings are applied together with each of the three event kinds. A wrong bit position, a crossing direction that is swapped, or an enable that is ignored each shows up as a different latch vector. Masked clears with a new pulse arriving in the same cycle separate set-wins from clear-wins, and they show that partial clears leave the other latches alone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NumFan  = 2;
  localparam int unsigned NumGpio = 4;
  localparam int unsigned NumTemp = 3;
  localparam int unsigned NumAin  = 2;

  // latch vector layout
  localparam int unsigned HpBase   = 0;
  localparam int unsigned TachBase = HpBase + NumFan;
  localparam int unsigned THiBase  = TachBase + NumFan;
  localparam int unsigned TLoBase  = THiBase + NumTemp;
  localparam int unsigned AHiBase  = TLoBase + NumTemp;
  localparam int unsigned ALoBase  = AHiBase + NumAin;
  localparam int unsigned LatchW   = ALoBase + NumAin;

  typedef struct packed {
    logic [LatchW-1:0] setVec;
    logic [LatchW-1:0] clrVec;
    logic              levelHit;
    logic              polHigh;
  } strobes_t;

  // returns {lowCrossingQualified, highQualified}
  function automatic logic [1:0] limitQualify(input logic hiEn, input logic loEn,
                                              input logic loRising, input logic hiEvt,
                                              input logic upEvt, input logic dnEvt);
    logic lo;
    lo = loEn & (loRising ? upEvt : dnEvt);
    return {lo, hiEn & hiEvt};
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic               rstN,
  input  logic               clk,
  input  logic               cfgForce,
  input  logic               cfgPolHigh,
  input  logic [NumFan-1:0]  hotPlugEvt,
  input  logic [NumGpio-1:0] gpioPin,
  input  logic [NumGpio-1:0] gpioIsInput,
  input  logic [NumGpio-1:0] gpioAssertHigh,
  input  logic [NumGpio-1:0] gpioIrqEn,
  input  logic [NumFan-1:0]  fanIrqEn,
  input  logic [NumFan-1:0]  tachOverEvt,
  input  logic [NumFan-1:0]  fanFaultN,
  input  logic [NumTemp-1:0] tempHiEn,
  input  logic [NumTemp-1:0] tempLoEn,
  input  logic [NumTemp-1:0] tempLoRising,
  input  logic [NumTemp-1:0] tempHiEvt,
  input  logic [NumTemp-1:0] tempLoUpEvt,
  input  logic [NumTemp-1:0] tempLoDnEvt,
  input  logic [NumAin-1:0]  ainHiEn,
  input  logic [NumAin-1:0]  ainLoEn,
  input  logic [NumAin-1:0]  ainLoRising,
  input  logic [NumAin-1:0]  ainHiEvt,
  input  logic [NumAin-1:0]  ainLoUpEvt,
  input  logic [NumAin-1:0]  ainLoDnEvt,
  input  logic               clrReq,
  input  logic [LatchW-1:0]  clrMask,
  output strobes_t           str
);
  logic [LatchW-1:0]  setVec;
  logic [NumGpio-1:0] gpioHit;
  logic [NumFan-1:0]  fanPinHit;

  for (genvar g = 0; g < NumGpio; g++) begin : gGpio
    assign gpioHit[g] = gpioIsInput[g] & gpioIrqEn[g] & (gpioPin[g] == gpioAssertHigh[g]);
  end

  for (genvar f = 0; f < NumFan; f++) begin : gFan
    assign setVec[HpBase+f]   = hotPlugEvt[f];
    assign setVec[TachBase+f] = fanIrqEn[f] & tachOverEvt[f];
    assign fanPinHit[f]       = fanIrqEn[f] & ~fanFaultN[f];
  end

  for (genvar t = 0; t < NumTemp; t++) begin : gTemp
    logic [1:0] q;
    assign q = limitQualify(tempHiEn[t], tempLoEn[t], tempLoRising[t],
                            tempHiEvt[t], tempLoUpEvt[t], tempLoDnEvt[t]);
    assign setVec[THiBase+t] = q[0];
    assign setVec[TLoBase+t] = q[1];

    // R10: a disabled high event never reaches the latch strobes
    a_r10_temp_hi_gated: assert property (@(posedge clk) disable iff (!rstN)
      (!tempHiEn[t]) |-> !str.setVec[THiBase+t]);
    // R8: wrong-direction crossing never reaches the latch strobes
    a_r8_temp_dir: assert property (@(posedge clk) disable iff (!rstN)
      (tempLoRising[t] && !tempLoUpEvt[t]) |-> !str.setVec[TLoBase+t]);
  end

  for (genvar a = 0; a < NumAin; a++) begin : gAin
    logic [1:0] q;
    assign q = limitQualify(ainHiEn[a], ainLoEn[a], ainLoRising[a],
                            ainHiEvt[a], ainLoUpEvt[a], ainLoDnEvt[a]);
    assign setVec[AHiBase+a] = q[0];
    assign setVec[ALoBase+a] = q[1];
  end

  always_comb begin
    str.setVec   = setVec;
    str.clrVec   = clrReq ? clrMask : '0;
    str.levelHit = cfgForce | (|gpioHit) | (|fanPinHit);
    str.polHigh  = cfgPolHigh;
  end

  // R5: a pin not configured as input never contributes a level
  a_r5_gpio_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    (gpioIsInput == '0 && !cfgForce && (fanIrqEn & ~fanFaultN) == '0) |-> !str.levelHit);
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          str,
  output logic [LatchW-1:0] latchedEvt,
  output logic              intOe
);
  logic [LatchW-1:0] stickyQ;
  logic [LatchW-1:0] stickyNext;
  logic              active;
  logic              oeQ;
  logic              pastOk;

  always_comb begin
    stickyNext = (stickyQ & ~str.clrVec) | str.setVec;
    active     = (|stickyNext) | str.levelHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
      oeQ     <= 1'b0;
      pastOk  <= 1'b0;
    end else begin
      stickyQ <= stickyNext;
      oeQ     <= active ^ str.polHigh;
      pastOk  <= 1'b1;
    end
  end

  assign latchedEvt = stickyQ;
  assign intOe      = oeQ;

  // R4: a latched bit survives unless the host clears it
  a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    1'b1 |=> ((($past(stickyQ) & ~$past(str.clrVec)) & ~stickyQ) == '0));
  // R11: a set strobe wins over a simultaneous clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    1'b1 |=> (($past(str.setVec) & ~stickyQ) == '0));
  // R10: no latch bit appears without a qualified set strobe
  a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    1'b1 |=> ((stickyQ & ~$past(stickyQ) & ~$past(str.setVec)) == '0));
  // R2: any latch held means the line shows the active level
  a_r2_latched_active: assert property (@(posedge clk) disable iff (!rstN)
    (|stickyNext) |=> (intOe == !$past(str.polHigh)));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgForce,
  input  logic               cfgPolHigh,
  input  logic [NumFan-1:0]  hotPlugEvt,
  input  logic [NumGpio-1:0] gpioPin,
  input  logic [NumGpio-1:0] gpioIsInput,
  input  logic [NumGpio-1:0] gpioAssertHigh,
  input  logic [NumGpio-1:0] gpioIrqEn,
  input  logic [NumFan-1:0]  fanIrqEn,
  input  logic [NumFan-1:0]  tachOverEvt,
  input  logic [NumFan-1:0]  fanFaultN,
  input  logic [NumTemp-1:0] tempHiEn,
  input  logic [NumTemp-1:0] tempLoEn,
  input  logic [NumTemp-1:0] tempLoRising,
  input  logic [NumTemp-1:0] tempHiEvt,
  input  logic [NumTemp-1:0] tempLoUpEvt,
  input  logic [NumTemp-1:0] tempLoDnEvt,
  input  logic [NumAin-1:0]  ainHiEn,
  input  logic [NumAin-1:0]  ainLoEn,
  input  logic [NumAin-1:0]  ainLoRising,
  input  logic [NumAin-1:0]  ainHiEvt,
  input  logic [NumAin-1:0]  ainLoUpEvt,
  input  logic [NumAin-1:0]  ainLoDnEvt,
  input  logic               clrReq,
  input  logic [LatchW-1:0]  clrMask,
  output logic [LatchW-1:0]  latchedEvt,
  output logic               intOe
);
  strobes_t str;

  irq_agg_ctrl i_ctrl (
    .rstN(rstN), .clk(clk),
    .cfgForce(cfgForce), .cfgPolHigh(cfgPolHigh),
    .hotPlugEvt(hotPlugEvt),
    .gpioPin(gpioPin), .gpioIsInput(gpioIsInput),
    .gpioAssertHigh(gpioAssertHigh), .gpioIrqEn(gpioIrqEn),
    .fanIrqEn(fanIrqEn), .tachOverEvt(tachOverEvt), .fanFaultN(fanFaultN),
    .tempHiEn(tempHiEn), .tempLoEn(tempLoEn), .tempLoRising(tempLoRising),
    .tempHiEvt(tempHiEvt), .tempLoUpEvt(tempLoUpEvt), .tempLoDnEvt(tempLoDnEvt),
    .ainHiEn(ainHiEn), .ainLoEn(ainLoEn), .ainLoRising(ainLoRising),
    .ainHiEvt(ainHiEvt), .ainLoUpEvt(ainLoUpEvt), .ainLoDnEvt(ainLoDnEvt),
    .clrReq(clrReq), .clrMask(clrMask),
    .str(str)
  );

  irq_agg_dp i_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .latchedEvt(latchedEvt), .intOe(intOe)
  );
endmodule

// File: tb/test_irq_agg_top.sv
`timescale 1ns/1ps
module test_irq_agg_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgForce = 0, cfgPolHigh = 0;
  logic [1:0] hotPlugEvt = '0;
  logic [3:0] gpioPin = '0, gpioIsInput = '0, gpioAssertHigh = '0, gpioIrqEn = '0;
  logic [1:0] fanIrqEn = '0, tachOverEvt = '0, fanFaultN = '1;
  logic [2:0] tempHiEn = '0, tempLoEn = '0, tempLoRising = '0;
  logic [2:0] tempHiEvt = '0, tempLoUpEvt = '0, tempLoDnEvt = '0;
  logic [1:0] ainHiEn = '0, ainLoEn = '0, ainLoRising = '0;
  logic [1:0] ainHiEvt = '0, ainLoUpEvt = '0, ainLoDnEvt = '0;
  logic clrReq = 0;
  logic [13:0] clrMask = '0;
  logic [13:0] latchedEvt;
  logic intOe;
  int nVec = 0, nBad = 0;

  always #2 clk = ~clk;

  irq_agg_top i_irq_agg_top (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clearAll();
    clrReq = 1; clrMask = '1; tick(); clrReq = 0; clrMask = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [13:0] exp;
    @(negedge clk); tick();
    check("R1 latches in reset", latchedEvt, 0);
    check("R1 line released in reset", intOe, 0);
    cfgPolHigh = 1; tick();
    check("R1 released in reset, high polarity", intOe, 0);
    cfgPolHigh = 0; rstN = 1; tick();
    check("R2 idle active-low", intOe, 0);

    // R5 sweep over pin mode bits, pin level and polarity
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 2; p++)
          for (int pol = 0; pol < 2; pol++) begin
            gpioIsInput = '0; gpioAssertHigh = '0; gpioIrqEn = '0;
            gpioIsInput[g] = b[0]; gpioAssertHigh[g] = b[1]; gpioIrqEn[g] = b[2];
            gpioPin = {4{p[0]}}; cfgPolHigh = pol[0];
            tick();
            check("R5 gpio level", intOe, (b[0] & b[2] & (p[0] == b[1])) ^ pol[0]);
          end
    gpioIsInput = '0; gpioIrqEn = '0; gpioAssertHigh = '0;

    // R3 force and R2 polarity
    for (int pol = 0; pol < 2; pol++) begin
      cfgPolHigh = pol[0]; cfgForce = 1; tick();
      check("R3 force active", intOe, 1 ^ pol[0]);
      check("R3 force latches nothing", latchedEvt, 0);
      cfgForce = 0; tick();
      check("R3 force released", intOe, pol[0]);
    end
    cfgPolHigh = 0;

    // R6 fan pin level and tach latch
    for (int f = 0; f < 2; f++)
      for (int en = 0; en < 2; en++) begin
        fanIrqEn = '0; fanIrqEn[f] = en[0];
        for (int pn = 0; pn < 2; pn++) begin
          fanFaultN = '1; fanFaultN[f] = pn[0]; tick();
          check("R6 fan pin", intOe, en[0] & ~pn[0]);
        end
        fanFaultN = '1;
        tachOverEvt[f] = 1; tick(); tachOverEvt = '0;
        exp = '0; exp[2+f] = en[0];
        check("R6 tach latch", latchedEvt, exp);
        check("R6 tach line", intOe, en[0]);
        clearAll();
        check("R11 clear all", latchedEvt, 0);
      end
    fanIrqEn = '0;

    // R7/R8/R9/R10 limit sweep: kind 0 temperature, 1 analog
    for (int k = 0; k < 2; k++)
      for (int ch = 0; ch < (k == 0 ? 3 : 2); ch++)
        for (int a = 0; a < 8; a++)
          for (int ev = 0; ev < 3; ev++) begin
            int hiB, loB;
            hiB = (k == 0) ? 4 : 10;
            loB = (k == 0) ? 7 : 12;
            if (k == 0) begin
              tempHiEn = '0; tempLoRising = '0; tempLoEn = '0;
              tempHiEn[ch] = a[0]; tempLoRising[ch] = a[1]; tempLoEn[ch] = a[2];
              tempHiEvt[ch] = (ev == 0); tempLoUpEvt[ch] = (ev == 1); tempLoDnEvt[ch] = (ev == 2);
            end else begin
              ainHiEn = '0; ainLoRising = '0; ainLoEn = '0;
              ainHiEn[ch] = a[0]; ainLoRising[ch] = a[1]; ainLoEn[ch] = a[2];
              ainHiEvt[ch] = (ev == 0); ainLoUpEvt[ch] = (ev == 1); ainLoDnEvt[ch] = (ev == 2);
            end
            tick();
            tempHiEvt = '0; tempLoUpEvt = '0; tempLoDnEvt = '0;
            ainHiEvt = '0; ainLoUpEvt = '0; ainLoDnEvt = '0;
            exp = '0;
            if (ev == 0 && a[0]) exp[hiB+ch] = 1;
            if (ev == 1 && a[2] && a[1]) exp[loB+ch] = 1;
            if (ev == 2 && a[2] && !a[1]) exp[loB+ch] = 1;
            if (exp == 0)
              check("R10 disabled event ignored", {18'd0, latchedEvt}, 0);
            else if (k == 1)
              check("R9 analog latch", latchedEvt, exp);
            else if (ev == 0)
              check("R7 temp high latch", latchedEvt, exp);
            else
              check("R8 temp low crossing latch", latchedEvt, exp);
            check("R10 line follows latch", intOe, |exp);
            clearAll();
          end
    tempHiEn = '0; tempLoEn = '0; ainHiEn = '0; ainLoEn = '0;

    // R4 hot-plug sticky, R11 masked clear
    hotPlugEvt = 2'b01; tick(); hotPlugEvt = 2'b10; tick(); hotPlugEvt = '0;
    check("R4 hot-plug both latched", latchedEvt, 14'h3);
    repeat (20) tick();
    check("R4 latch sticky", latchedEvt, 14'h3);
    check("R4 line held", intOe, 1);
    clrReq = 1; clrMask = 14'h1; tick(); clrReq = 0; clrMask = '0;
    check("R11 masked clear", latchedEvt, 14'h2);
    check("R11 line held by remaining bit", intOe, 1);
    cfgPolHigh = 1; tick();
    check("R2 high polarity active releases", intOe, 0);
    cfgPolHigh = 0;
    clrReq = 1; clrMask = 14'h2; hotPlugEvt = 2'b10; tick();
    clrReq = 0; clrMask = '0; hotPlugEvt = '0;
    check("R11 set wins over clear", latchedEvt, 14'h2);
    clearAll();
    check("R11 cleared", latchedEvt, 0);
    check("R2 line released after clear", intOe, 0);
    cfgPolHigh = 1; tick();
    check("R2 high polarity idle pulls", intOe, 1);
    summary();
  end
endmodule